// File: doc/BRIEF.md
# Half-Word Result Packer with Output FIFO

This block collects 16-bit conversion results and assembles them into 32-bit output words, then queues the finished words in an eight-entry FIFO. A 2-bit packing mode chooses the assembly. Two modes put each result alone in the upper or the lower half of a word and zero the other half. The other two modes pair consecutive results in one word, with the earlier result in the upper half or in the lower half. Only the result that completes a word produces a word and a conversion-complete event.

A bus reader sees the word at the FIFO head on `rdData` and removes it with a one-cycle `rdStrobe`. Several status outputs are always live: the FIFO level, a data-ready flag, and a bit that tells which half-word the next result will fill. Conversion-complete, overrun and underrun each drive a one-cycle event pulse. Separate enables gate each pulse into a single interrupt request.

Top module: `respack_top`

## Requirements
- R1: With `packMode` = 0, each accepted result becomes a word `{result, 16'h0000}` that is pushed to the FIFO, and `cmplPulse` is high for one cycle in the cycle after the result is sampled.
- R2: With `packMode` = 1, each accepted result becomes a word `{16'h0000, result}` that is pushed to the FIFO, with `cmplPulse` timed as in R1.
- R3: With `packMode` = 2, two accepted results form one word in which the earlier result sits in bits 31:16 and the later result in bits 15:0. Only the second result pushes the word and raises `cmplPulse`.
- R4: With `packMode` = 3, two accepted results form one word in which the earlier result sits in bits 15:0 and the later result in bits 31:16. Only the second result pushes the word and raises `cmplPulse`.
- R5: `nextUpper` shows where the next accepted result will land: 1 for bits 31:16 and 0 for bits 15:0. It is always 1 in mode 0 and always 0 in mode 1, and in modes 2 and 3 it follows the current half of the pair.
- R6: The FIFO holds up to 8 words in arrival order. `rdData` shows the oldest word, `rdStrobe` removes it, `fifoLevel` gives the word count, and `dataReady` is 1 exactly when that count is nonzero.
- R7: A completed word that arrives while the FIFO holds 8 words and `rdStrobe` is low is dropped, and `ovrPulse` is high in the next cycle. If `rdStrobe` is high in that same cycle, the oldest word leaves, the new word is stored, and no overrun is reported.
- R8: `rdStrobe` on an empty FIFO leaves the level unchanged, `rdData` reads 0 in that cycle, and `undPulse` is high in the next cycle. A word completed in the same cycle is still stored.
- R9: In a cycle where `enable` is low, or where `packMode` differs from its value in the previous cycle, the pair pointer returns to the first half, any stored first half is discarded, and a result presented in that cycle is ignored.
- R10: `irq` is high in exactly the cycles where `(cmplPulse & ienCmpl) | (ovrPulse & ienOvr) | (undPulse & ienUnd)` holds, with each enable sampled together with the input that caused its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; results are ignored while low |
| packMode | input | 2 | Packing mode 0..3 |
| resValid | input | 1 | Result strobe |
| resData | input | DATA_W (16) | Conversion result |
| rdStrobe | input | 1 | Pop the FIFO head |
| ienCmpl | input | 1 | Enable for the conversion-complete interrupt |
| ienOvr | input | 1 | Enable for the overrun interrupt |
| ienUnd | input | 1 | Enable for the underrun interrupt |
| rdData | output | 2*DATA_W (32) | FIFO head word, or 0 when empty |
| nextUpper | output | 1 | Half that the next result will fill (1 = upper) |
| dataReady | output | 1 | FIFO is not empty |
| fifoLevel | output | LVL_W (4) | Number of words in the FIFO |
| cmplPulse | output | 1 | A word was completed |
| ovrPulse | output | 1 | A completed word was dropped |
| undPulse | output | 1 | A read was made on an empty FIFO |
| irq | output | 1 | Gated OR of the event pulses |

## Verification
A push and a pop can fall in the same cycle. This case decides the outcome at both ends of the FIFO. When the FIFO is full, a word that completes in the same cycle as a read must be stored and must not raise an overrun. When the FIFO is empty, a read in the same cycle as a completing word must raise an underrun and still keep the word. The bench provokes both cases with directed sequences, and random traffic adds more of them. A cycle-level reference model computes the expected level, head word and pulses.

// File: rtl/respack_pkg.sv
package respack_pkg;

  typedef enum logic [1:0] {
    PK_HI_ONLY  = 2'd0,
    PK_LO_ONLY  = 2'd1,
    PK_HI_FIRST = 2'd2,
    PK_LO_FIRST = 2'd3
  } packMode_e;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic latchFirst;      // hold this result as first half of a pair
    logic newInUpper;      // this result lands in the upper half
    logic pairWithPartial; // other half comes from the held result
    logic doPush;          // write the assembled word into the FIFO
    logic doPop;           // remove the head word
  } packStrobe_t;

endpackage

// File: rtl/respack_ctrl.sv
module respack_ctrl
  import respack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  packMode,
  input  logic        resValid,
  input  logic        rdStrobe,
  input  logic        ienCmpl,
  input  logic        ienOvr,
  input  logic        ienUnd,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  output packStrobe_t strobes,
  output logic        nextUpper,
  output logic        cmplPulse,
  output logic        ovrPulse,
  output logic        undPulse,
  output logic        irq
);

  logic [1:0] modeQ;
  logic       secondQ;
  logic       clearNow;
  logic       accept;
  logic       dualMode;
  logic       secondEff;
  logic       complete;
  logic       landUpper;
  logic       overrun;
  logic       underrun;

  assign clearNow  = !enable || (packMode != modeQ);
  assign accept    = resValid && !clearNow;
  assign dualMode  = packMode[1];
  assign secondEff = secondQ && !clearNow;
  assign complete  = accept && (!dualMode || secondEff);

  always_comb begin
    unique case (packMode_e'(packMode))
      PK_HI_ONLY:  landUpper = 1'b1;
      PK_LO_ONLY:  landUpper = 1'b0;
      PK_HI_FIRST: landUpper = !secondEff;
      default:     landUpper = secondEff;
    endcase
  end

  assign nextUpper = landUpper;
  assign overrun   = complete && fifoFull && !rdStrobe;
  assign underrun  = rdStrobe && fifoEmpty;

  always_comb begin
    strobes.latchFirst      = accept && dualMode && !secondEff;
    strobes.newInUpper      = landUpper;
    strobes.pairWithPartial = dualMode;
    strobes.doPop           = rdStrobe && !fifoEmpty;
    strobes.doPush          = complete && (!fifoFull || rdStrobe);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= 2'd0;
      secondQ   <= 1'b0;
      cmplPulse <= 1'b0;
      ovrPulse  <= 1'b0;
      undPulse  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      modeQ <= packMode;
      if (clearNow)
        secondQ <= 1'b0;
      else if (accept && dualMode)
        secondQ <= !secondQ;
      cmplPulse <= complete;
      ovrPulse  <= overrun;
      undPulse  <= underrun;
      irq       <= (complete && ienCmpl) || (overrun && ienOvr) || (underrun && ienUnd);
    end
  end

endmodule

// File: rtl/respack_data.sv
module respack_data
  import respack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int WORD_W = 2 * DATA_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  packStrobe_t       strobes,
  input  logic [DATA_W-1:0] resData,
  output logic [WORD_W-1:0] rdData,
  output logic [LVL_W-1:0]  level,
  output logic              fifoFull,
  output logic              fifoEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] partialQ;
  logic [DATA_W-1:0] otherHalf;
  logic [WORD_W-1:0] assembled;
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  assign otherHalf = strobes.pairWithPartial ? partialQ : '0;
  assign assembled = strobes.newInUpper ? {resData, otherHalf} : {otherHalf, resData};

  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign fifoEmpty = (level == '0);
  assign rdData    = fifoEmpty ? '0 : store[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.doPush)
      store[wrPtr] <= assembled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partialQ <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
    end else begin
      if (strobes.latchFirst)
        partialQ <= resData;
      if (strobes.doPush)
        wrPtr <= bump(wrPtr);
      if (strobes.doPop)
        rdPtr <= bump(rdPtr);
      case ({strobes.doPush, strobes.doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/respack_top.sv
module respack_top
  import respack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int WORD_W = 2 * DATA_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        packMode,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic              rdStrobe,
  input  logic              ienCmpl,
  input  logic              ienOvr,
  input  logic              ienUnd,
  output logic [WORD_W-1:0] rdData,
  output logic              nextUpper,
  output logic              dataReady,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              cmplPulse,
  output logic              ovrPulse,
  output logic              undPulse,
  output logic              irq
);

  packStrobe_t strobes;
  logic        fifoFull;
  logic        fifoEmpty;

  respack_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .packMode  (packMode),
    .resValid  (resValid),
    .rdStrobe  (rdStrobe),
    .ienCmpl   (ienCmpl),
    .ienOvr    (ienOvr),
    .ienUnd    (ienUnd),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .strobes   (strobes),
    .nextUpper (nextUpper),
    .cmplPulse (cmplPulse),
    .ovrPulse  (ovrPulse),
    .undPulse  (undPulse),
    .irq       (irq)
  );

  respack_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .resData   (resData),
    .rdData    (rdData),
    .level     (fifoLevel),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty)
  );

  assign dataReady = !fifoEmpty;

endmodule

// File: rtl/respack_chk.sv
module respack_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int WORD_W = 2 * DATA_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [1:0]        packMode,
  input logic              resValid,
  input logic [DATA_W-1:0] resData,
  input logic              rdStrobe,
  input logic              ienCmpl,
  input logic              ienOvr,
  input logic              ienUnd,
  input logic [WORD_W-1:0] rdData,
  input logic              nextUpper,
  input logic              dataReady,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              cmplPulse,
  input logic              ovrPulse,
  input logic              undPulse,
  input logic              irq
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH)); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fifoLevel == '0) |-> (rdData == '0 && !dataReady)); // R8

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fifoLevel == '0) |=> undPulse); // R8

  AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ovrPulse |-> ($past(fifoLevel) == LVL_W'(DEPTH) && fifoLevel == LVL_W'(DEPTH))); // R7

  AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && packMode[1] && resValid && $past(rstN) && packMode == $past(packMode))
    |=> (!(enable && packMode == $past(packMode)) || nextUpper != $past(nextUpper))); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (cmplPulse || ovrPulse || undPulse)); // R10

endmodule

bind respack_top respack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/respack_top_tb.sv
module respack_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  packMode = 2'd0;
  logic        resValid = 1'b0;
  logic [15:0] resData = 16'h0;
  logic        rdStrobe = 1'b0;
  logic        ienCmpl = 1'b1;
  logic        ienOvr = 1'b1;
  logic        ienUnd = 1'b1;
  logic [31:0] rdData;
  logic        nextUpper;
  logic        dataReady;
  logic [3:0]  fifoLevel;
  logic        cmplPulse;
  logic        ovrPulse;
  logic        undPulse;
  logic        irq;

  respack_top u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .packMode(packMode),
    .resValid(resValid), .resData(resData), .rdStrobe(rdStrobe),
    .ienCmpl(ienCmpl), .ienOvr(ienOvr), .ienUnd(ienUnd),
    .rdData(rdData), .nextUpper(nextUpper), .dataReady(dataReady),
    .fifoLevel(fifoLevel), .cmplPulse(cmplPulse), .ovrPulse(ovrPulse),
    .undPulse(undPulse), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string phaseTag = "R6";

  // reference model state
  logic [31:0] q[$];
  logic [15:0] mPartial = 16'h0;
  logic        mSecond = 1'b0;
  logic [1:0]  mMode = 2'd0;
  logic        eC = 0, eO = 0, eU = 0, eI = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic expNextUpper();
    logic s;
    s = mSecond && enable && (packMode == mMode);
    case (packMode)
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return !s;
      default: return s;
    endcase
  endfunction

  // advance the model by one clock edge with the inputs now driven
  task automatic modelStep();
    logic clr, comp, full, popOk;
    logic [31:0] w;
    clr = !enable || (packMode != mMode);
    comp = 0;
    w = 32'h0;
    if (!clr && resValid) begin
      case (packMode)
        2'd0: begin w = {resData, 16'h0}; comp = 1; end
        2'd1: begin w = {16'h0, resData}; comp = 1; end
        2'd2: if (!mSecond) begin mPartial = resData; mSecond = 1; end
              else begin w = {mPartial, resData}; comp = 1; mSecond = 0; end
        default: if (!mSecond) begin mPartial = resData; mSecond = 1; end
              else begin w = {resData, mPartial}; comp = 1; mSecond = 0; end
      endcase
    end
    if (clr) mSecond = 0;
    full  = (q.size() == DEPTH);
    popOk = rdStrobe && q.size() > 0;
    eU = rdStrobe && q.size() == 0;
    eO = comp && full && !rdStrobe;
    eC = comp;
    eI = (eC && ienCmpl) || (eO && ienOvr) || (eU && ienUnd);
    if (popOk) void'(q.pop_front());
    if (comp && !eO) q.push_back(w);
    mMode = packMode;
  endtask

  task automatic checkAll();
    chk(phaseTag, "rdData", rdData, (q.size() > 0) ? q[0] : 32'h0);
    chk("R6", "fifoLevel", 32'(fifoLevel), 32'(q.size()));
    chk("R6", "dataReady", 32'(dataReady), 32'(q.size() > 0));
    chk("R5", "nextUpper", 32'(nextUpper), 32'(expNextUpper()));
    chk("R1", "cmplPulse", 32'(cmplPulse), 32'(eC));
    chk("R7", "ovrPulse", 32'(ovrPulse), 32'(eO));
    chk("R8", "undPulse", 32'(undPulse), 32'(eU));
    chk("R10", "irq", 32'(irq), 32'(eI));
  endtask

  task automatic cyc(logic v, logic [15:0] d, logic rd);
    resValid = v;
    resData  = d;
    rdStrobe = rd;
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  task automatic setMode(logic [1:0] m);
    packMode = m;
    cyc(1'b1, 16'hDEAD, 1'b0); // result in the change cycle is ignored (R9)
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6", "reset level", 32'(fifoLevel), 32'h0);
    chk("R6", "reset rdData", rdData, 32'h0);
    chk("R10", "reset irq", 32'(irq), 32'h0);
    enable = 1'b1;

    phaseTag = "R1";
    cyc(1'b1, 16'h1111, 1'b0);
    cyc(1'b1, 16'h2222, 1'b0);
    cyc(1'b1, 16'h3333, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);

    phaseTag = "R2";
    setMode(2'd1);
    cyc(1'b1, 16'hA5A5, 1'b0);
    cyc(1'b1, 16'h5A5A, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);

    phaseTag = "R3";
    setMode(2'd2);
    cyc(1'b1, 16'h0102, 1'b0);
    cyc(1'b0, 16'h0, 1'b0);
    cyc(1'b1, 16'h0304, 1'b0);
    cyc(1'b1, 16'h0506, 1'b0);
    cyc(1'b1, 16'h0708, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);

    phaseTag = "R4";
    setMode(2'd3);
    cyc(1'b1, 16'hAAAA, 1'b0);
    cyc(1'b1, 16'hBBBB, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);

    phaseTag = "R9";
    cyc(1'b1, 16'hC0C0, 1'b0);      // first half held
    setMode(2'd2);                  // discard it
    cyc(1'b1, 16'h1234, 1'b0);
    cyc(1'b1, 16'h5678, 1'b0);
    cyc(1'b1, 16'h9999, 1'b0);      // first half held
    enable = 1'b0;
    cyc(1'b1, 16'hEEEE, 1'b0);      // ignored, pointer cleared
    enable = 1'b1;
    cyc(1'b1, 16'h4321, 1'b0);
    cyc(1'b1, 16'h8765, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);

    phaseTag = "R7";
    setMode(2'd0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 16'(16'h100 + i), 1'b0);
    cyc(1'b1, 16'h7777, 1'b1);      // full: push and pop together
    ienOvr = 1'b0;
    cyc(1'b1, 16'h7778, 1'b0);      // overrun with interrupt masked
    ienOvr = 1'b1;

    phaseTag = "R8";
    for (int i = 0; i < 9; i++) cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b1, 16'h6666, 1'b1);      // empty: read and push together
    cyc(1'b0, 16'h0, 1'b1);
    ienUnd = 1'b0;
    cyc(1'b0, 16'h0, 1'b1);
    ienUnd = 1'b1;

    phaseTag = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 39) == 0) packMode = 2'($urandom_range(0, 3));
      enable  = ($urandom_range(0, 19) != 0);
      ienCmpl = ($urandom_range(0, 3) != 0);
      ienOvr  = ($urandom_range(0, 3) != 0);
      ienUnd  = ($urandom_range(0, 3) != 0);
      cyc($urandom_range(0, 9) < 6, 16'($urandom), $urandom_range(0, 9) < 4);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule